// File: doc/BRIEF.md
# Dual Event Counter with Tick Generation

This block counts hardware events on two independent channels. Each channel selects one of eight single-cycle event strobes, adds up the strobes it sees and raises a one-cycle tick each time a power-of-two number of events has gone by. One control bit per channel picks between a short and a long tick period. The two channels use different period pairs, so channel 1 can run faster than channel 0.

Channel 0 has two derived sources that need an issue count of 0, 1 or 2 for each cycle. The issue source adds a full event in a cycle with two issues and half an event in a cycle with one issue. The non-issue source adds a full event in a cycle with no issue and half an event in a cycle with one issue. Each channel also has a disable bit. A disabled channel still ticks, but it raises a drop flag with the tick so that the consumer records nothing from it.

A 16-bit register port sets the configuration and reads back the configuration and the sticky tick status. A write that would disable both channels is refused, and so is a write that sets any reserved bit. All pins are plain control and status signals. Nothing here flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_evt_ctr`

## Requirements
- R1: After reset the configuration word (address 0) and the status word (address 1) read as 0, and `tick`, `tick_drop` and `reg_err` are low.
- R2: Channel 0 ticks after 2^12 counted events when its period bit (config bit 3) is 1, and after 2^16 events when the bit is 0.
- R3: Channel 1 ticks after 2^8 counted events when its period bit (config bit 7) is 1, and after 2^12 events when the bit is 0.
- R4: A write to address 0 is refused when the disable field (bits 9:8) equals 3 or when any of bits 15:10 is set. A refused write leaves the configuration unchanged and pulses `reg_err` for the single cycle after the write.
- R5: With channel 0 select (bits 2:0) equal to 0, a cycle with `issue_cnt`=2 adds one event and a cycle with `issue_cnt`=1 adds half an event.
- R6: With channel 0 select equal to 7, a cycle with `issue_cnt`=0 adds one event, a cycle with `issue_cnt`=1 adds half an event and a cycle with `issue_cnt`=2 adds nothing.
- R7: A strobe source adds one event for each clock cycle in which it is high. Channel 0 select values 1 to 6 pick `ev0[sel-1]`, and channel 1 select (bits 6:4) values 0 to 7 pick `ev1[sel]`.
- R8: When a channel's disable bit is set (bit 8 for channel 0, bit 9 for channel 1), the channel still ticks, and `tick_drop` for that channel is high in the tick cycle. A dropped tick does not set the channel's status bit.
- R9: Each tick lasts one cycle. A tick that is not dropped sets status bit c (bit 0 for channel 0, bit 1 for channel 1) at address 1. The bit stays set until a write to address 1 with a 1 in that bit position clears it.
- R10: An accepted configuration write that changes a channel's select or period bit clears that channel's partial count. The event in the write cycle is not counted, so the next tick comes a full period after the write.
- R11: An accepted write to address 0 reads back exactly at address 0, with bits 15:10 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration word, 1 = status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| reg_err | output | 1 | One-cycle pulse when a configuration write is refused |
| issue_cnt | input | 2 | Instructions issued this cycle (0, 1 or 2) |
| ev0 | input | 6 | Strobe sources for channel 0 selects 1 to 6 |
| ev1 | input | 8 | Strobe sources for channel 1 selects 0 to 7 |
| tick | output | 2 | One-cycle tick per channel |
| tick_drop | output | 2 | Discard flag that goes with each tick |

## Verification
The properties assume that `issue_cnt` never carries the value 3 and that each strobe is a level that is sampled once per clock. Under these assumptions two ticks of one channel can never fall in adjacent cycles. The stimulus drives every input half a period away from the active edge and sets `issue_cnt` only to 0, 1 or 2. It keeps the strobe of every source that is not selected low, so each run can be tied to one source. Each table run starts from reset, which means the expected tick cycle is the exact event count and does not depend on a leftover partial count.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int SEL_W  = 3;
  localparam int NUM_EV = 1 << SEL_W;
  localparam int CFG_W  = 10;
  localparam int REG_W  = 16;
  localparam int NCH    = 2;
  localparam logic [SEL_W-1:0] SEL_ISSUE    = '0;
  localparam logic [SEL_W-1:0] SEL_NONISSUE = '1;

  typedef struct packed {
    logic [1:0]       dis;
    logic             fast1;
    logic [SEL_W-1:0] sel1;
    logic             fast0;
    logic [SEL_W-1:0] sel0;
  } cfg_t;
endpackage

// File: rtl/evc_src_mux.sv
module evc_src_mux import evc_pkg::*; #(
  parameter bit HAS_ISSUE = 1'b0
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_EV-1:0] ev,
  input  logic [1:0]        issue_cnt,
  output logic [1:0]        inc_half
);
  logic [1:0] issue_wt;
  logic [1:0] idle_wt;

  always_comb begin
    unique case (issue_cnt)
      2'd0:    begin issue_wt = 2'd0; idle_wt = 2'd2; end
      2'd1:    begin issue_wt = 2'd1; idle_wt = 2'd1; end
      default: begin issue_wt = 2'd2; idle_wt = 2'd0; end
    endcase
  end

  always_comb begin
    if (HAS_ISSUE && sel == SEL_ISSUE)         inc_half = issue_wt;
    else if (HAS_ISSUE && sel == SEL_NONISSUE) inc_half = idle_wt;
    else                                       inc_half = {ev[sel], 1'b0};
  end
endmodule

// File: rtl/evc_prescaler.sv
module evc_prescaler #(
  parameter int FAST_LOG = 8,
  parameter int SLOW_LOG = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       fast,
  input  logic [1:0] inc_half,
  output logic       tick_o
);
  localparam int MAX_LOG = (FAST_LOG > SLOW_LOG) ? FAST_LOG : SLOW_LOG;
  localparam int ACC_W   = MAX_LOG + 2;
  localparam logic [ACC_W-1:0] FAST_HALVES = ACC_W'(1) << (FAST_LOG + 1);
  localparam logic [ACC_W-1:0] SLOW_HALVES = ACC_W'(1) << (SLOW_LOG + 1);

  logic [ACC_W-1:0] acc_q, sum, period;
  logic             hit;

  always_comb begin
    period = fast ? FAST_HALVES : SLOW_HALVES;
    sum    = acc_q + ACC_W'(inc_half);
    hit    = (sum >= period);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= hit ? (sum - period) : sum;
      tick_o <= hit;
    end
  end
endmodule

// File: rtl/evc_ctrl_regs.sv
module evc_ctrl_regs import evc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_err,
  input  logic [NCH-1:0]   tick,
  output cfg_t             cfg_q,
  output logic [NCH-1:0]   status_q,
  output logic [NCH-1:0]   restart
);
  cfg_t           cfg_n;
  logic           wr_cfg, bad, take;
  logic [NCH-1:0] clr, kept;

  always_comb begin
    cfg_n  = cfg_t'(reg_wdata[CFG_W-1:0]);
    wr_cfg = reg_we && !reg_addr;
    bad    = (cfg_n.dis == 2'b11) || (|reg_wdata[REG_W-1:CFG_W]);
    take   = wr_cfg && !bad;
    restart[0] = take && ((cfg_n.sel0 != cfg_q.sel0) || (cfg_n.fast0 != cfg_q.fast0));
    restart[1] = take && ((cfg_n.sel1 != cfg_q.sel1) || (cfg_n.fast1 != cfg_q.fast1));
    clr  = (reg_we && reg_addr) ? reg_wdata[NCH-1:0] : '0;
    kept = tick & ~cfg_q.dis;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      status_q <= '0;
      reg_err  <= 1'b0;
    end else begin
      reg_err <= wr_cfg && bad;
      if (take) cfg_q <= cfg_n;
      status_q <= (status_q & ~clr) | kept;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata[NCH-1:0]   = status_q;
    else          reg_rdata[CFG_W-1:0] = cfg_q;
  end
endmodule

// File: rtl/dual_evt_ctr.sv
module dual_evt_ctr import evc_pkg::*; #(
  parameter int CH0_FAST_LOG = 12,
  parameter int CH0_SLOW_LOG = 16,
  parameter int CH1_FAST_LOG = 8,
  parameter int CH1_SLOW_LOG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_err,
  input  logic [1:0]        issue_cnt,
  input  logic [NUM_EV-3:0] ev0,
  input  logic [NUM_EV-1:0] ev1,
  output logic [NCH-1:0]    tick,
  output logic [NCH-1:0]    tick_drop
);
  cfg_t                         cfg_q;
  logic [NCH-1:0]               status_q;
  logic [NCH-1:0]               restart;
  logic [NCH-1:0][NUM_EV-1:0]   ev_vec;
  logic [NCH-1:0][SEL_W-1:0]    sel_vec;
  logic [NCH-1:0]               fast_vec;

  always_comb begin
    ev_vec[0]   = {1'b0, ev0, 1'b0};
    ev_vec[1]   = ev1;
    sel_vec[0]  = cfg_q.sel0;
    sel_vec[1]  = cfg_q.sel1;
    fast_vec[0] = cfg_q.fast0;
    fast_vec[1] = cfg_q.fast1;
    tick_drop   = tick & cfg_q.dis;
  end

  evc_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_err   (reg_err),
    .tick      (tick),
    .cfg_q     (cfg_q),
    .status_q  (status_q),
    .restart   (restart)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] inc_half;

    evc_src_mux #(.HAS_ISSUE(c == 0)) u_mux (
      .sel       (sel_vec[c]),
      .ev        (ev_vec[c]),
      .issue_cnt (issue_cnt),
      .inc_half  (inc_half)
    );

    evc_prescaler #(
      .FAST_LOG ((c == 0) ? CH0_FAST_LOG : CH1_FAST_LOG),
      .SLOW_LOG ((c == 0) ? CH0_SLOW_LOG : CH1_SLOW_LOG)
    ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart[c]),
      .fast     (fast_vec[c]),
      .inc_half (inc_half),
      .tick_o   (tick[c])
    );
  end
endmodule

// File: rtl/evc_chk.sv
module evc_chk import evc_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             reg_err,
  input logic [NCH-1:0]   tick,
  input logic [NCH-1:0]   tick_drop,
  input logic [CFG_W-1:0] cfg_q,
  input logic [NCH-1:0]   status_q,
  input logic [NCH-1:0]   restart
);
  // R4
  cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr && reg_wdata[9:8] == 2'b11) |=> (reg_err && $stable(cfg_q)));

  // R4
  dis_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[9:8] != 2'b11);

  for (genvar c = 0; c < NCH; c++) begin : g_p
    // R9
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |=> !tick[c]);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[c] && !(reg_we && reg_addr && reg_wdata[c])) |=> status_q[c]);

    // R9
    kept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && !tick_drop[c]) |=> status_q[c]);

    // R8
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_drop[c] && !status_q[c]) |=> !status_q[c]);

    // R10
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart[c] |=> !tick[c]);
  end
endmodule

bind dual_evt_ctr evc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_err   (reg_err),
  .tick      (tick),
  .tick_drop (tick_drop),
  .cfg_q     (cfg_q),
  .status_q  (status_q),
  .restart   (restart)
);

// File: tb/sim_dual_evt_ctr.sv
module sim_dual_evt_ctr;
  localparam int PERIOD = 10;
  localparam int NROW = 10;
  // Row fields: config word, drive kind (0 = ev0 bit, 1 = ev1 bit, 2 = issue_cnt), argument,
  // channel, events until tick, expected drop flag
  localparam logic [15:0] V_CFG  [NROW] = '{16'h00B0, 16'h0008, 16'h0008, 16'h000F, 16'h000F,
                                            16'h0050, 16'h02A0, 16'h000C, 16'h0001, 16'h010E};
  localparam int          V_KIND [NROW] = '{1, 2, 2, 2, 2, 1, 1, 0, 0, 0};
  localparam int          V_ARG  [NROW] = '{3, 2, 1, 0, 1, 5, 2, 3, 0, 5};
  localparam int          V_CH   [NROW] = '{1, 0, 0, 0, 0, 1, 1, 0, 0, 0};
  localparam int          V_N    [NROW] = '{256, 4096, 8192, 4096, 8192, 4096, 256, 4096, 65536, 4096};
  localparam bit          V_DROP [NROW] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
  localparam string       V_REQ  [NROW] = '{"R3 R7", "R2 R5", "R5", "R6", "R6", "R3", "R8",
                                            "R7", "R2", "R8"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_err;
  logic [1:0]  issue_cnt = '0;
  logic [5:0]  ev0 = '0;
  logic [7:0]  ev1 = '0;
  logic [1:0]  tick, tick_drop;

  int checks = 0;
  int errors = 0;

  dual_evt_ctr u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue_cnt = '0; ev0 = '0; ev1 = '0; reg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic addr, input logic [15:0] d, output logic err);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    err = reg_err;
  endtask

  task automatic rd(input logic addr, output logic [15:0] d);
    reg_addr = addr;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input int kind, input int arg, input bit on);
    if (kind == 0)      ev0[arg] = on;
    else if (kind == 1) ev1[arg] = on;
    else                issue_cnt = on ? 2'(arg) : 2'd0;
  endtask

  // Hold a source for n cycles; report cycle of first tick, its drop flag and tick count.
  task automatic run(input int kind, input int arg, input int ch, input int n,
                     output int first, output bit drop, output int cnt);
    first = -1; drop = 1'b0; cnt = 0;
    drive(kind, arg, 1'b1);
    for (int i = 1; i <= n + 2; i++) begin
      @(negedge clk);
      if (tick[ch]) begin
        cnt++;
        if (first < 0) begin first = i; drop = tick_drop[ch]; end
      end
      if (i == n) drive(kind, arg, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    logic        e;
    int          first, cnt;
    bit          drop;

    do_reset();
    // R1 reset state
    rd(1'b0, d); check("R1 cfg", d, 0);
    rd(1'b1, d); check("R1 status", d, 0);
    check("R1 tick", {tick, tick_drop, reg_err}, 0);

    for (int r = 0; r < NROW; r++) begin
      do_reset();
      wr(1'b0, V_CFG[r], e);
      check({V_REQ[r], " write ok"}, e, 0);
      run(V_KIND[r], V_ARG[r], V_CH[r], V_N[r], first, drop, cnt);
      check({V_REQ[r], " tick cycle"}, first, V_N[r]);
      check({V_REQ[r], " tick count"}, cnt, 1);
      check({V_REQ[r], " drop flag"}, drop, V_DROP[r]);
      rd(1'b1, d);
      check({V_REQ[r], " R9 status"}, d, V_DROP[r] ? 16'h0 : (16'h1 << V_CH[r]));
    end

    // R4 and R11: refused and accepted writes
    do_reset();
    wr(1'b0, 16'h00B0, e);
    rd(1'b0, d); check("R11 readback", d, 16'h00B0);
    wr(1'b0, 16'h0300, e);
    check("R4 err on dis=3", e, 1);
    rd(1'b0, d); check("R4 cfg kept after dis=3", d, 16'h00B0);
    @(negedge clk);
    check("R4 err one cycle", reg_err, 0);
    wr(1'b0, 16'h0400 | 16'h0050, e);
    check("R4 err on reserved", e, 1);
    rd(1'b0, d); check("R4 cfg kept after reserved", d, 16'h00B0);
    wr(1'b0, 16'h0155, e);
    check("R4 no err on legal", e, 0);
    rd(1'b0, d); check("R11 readback legal", d, 16'h0155);

    // R10: partial count cleared on select change
    do_reset();
    wr(1'b0, 16'h00B0, e);
    run(1, 3, 1, 200, first, drop, cnt);
    check("R10 no early tick", cnt, 0);
    wr(1'b0, 16'h00C0, e);
    run(1, 4, 1, 256, first, drop, cnt);
    check("R10 full period after change", first, 256);

    // R9: write-one-to-clear of status
    rd(1'b1, d); check("R9 status set", d, 16'h2);
    wr(1'b1, 16'h0001, e);
    rd(1'b1, d); check("R9 other bit kept", d, 16'h2);
    wr(1'b1, 16'h0002, e);
    rd(1'b1, d); check("R9 cleared", d, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule